// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Controller

This controller moves one byte at a time over a three-wire full-duplex serial link (clock, data out, data in) with an active-low select line. A small register port lets a processor configure it as the clock-driving master or as a slave that follows an external clock. Each byte sent is swapped for a byte received in the same eight bit periods. Clock polarity, clock phase and bit order are set in the control register. In master mode the serial clock comes from the system clock through a prescaler with seven distinct rates.

Each completed byte raises a completion flag, which can also drive an interrupt request. Writing the data register while a byte is still moving sets a collision flag, and that write is discarded. Both flags clear when software reads the status register while a flag is up and then accesses the data register. A slave that loses its select partway through a byte drops the partial byte and stops driving its data output.

Register map on `reg_addr`: 0 = control, 1 = status, 2 = data (a write loads the transmit byte, a read returns the last received byte), 3 = select. Control bits: [1:0] rate, [2] phase, [3] idle clock level, [4] master, [5] low bit first, [6] enable, [7] interrupt enable. Status bits: [7] completion, [6] collision, [0] double speed (writable).

Top module: `spi_port`

## Requirements
- R1: In master mode with enable set, a data write while idle starts a byte. The eight bits of the written byte go out on `sdo`, eight bits are taken from `sdi` at the same time, and when the byte ends the received byte can be read at address 2.
- R2: Control bit 4 selects the mode. A master drives `sck_out` with `sck_oe` high. A slave keeps `sck_oe` low, clocks on `sck_in` and drives `sdo` only while `sel_in_n` is low.
- R3: Bit 0 of the select register (address 3) drives `sel_out_n` low when it is 1 and high when it is 0. Reset leaves it high.
- R4: Control bit 5 set shifts the least significant bit first, and clear shifts the most significant bit first. When the two ends use opposite orders, each end receives the other's byte bit-reversed.
- R5: A master byte lasts 16·H system clocks from the data write to the completion flag, where the divisor 2·H is 4, 16, 64, 128 for rate 0..3 with double speed clear.
- R6: With status bit 0 (double speed) set, the divisors for rate 0..3 are 2, 8, 32, 64. The fastest rate is the system clock divided by 2.
- R7: Status bit 7 sets when a byte completes. `irq` equals that flag ANDed with control bit 7.
- R8: A data write while a byte is in flight sets status bit 6. The write is ignored, and the byte in flight finishes with its original data.
- R9: A data access clears bits 7 and 6 only when it follows a status read that saw one of them set. A data read with no such status read leaves the flags set.
- R10: If a slave's select rises partway through a byte, `sdo_oe` goes low, no completion flag is set and the received-byte register is unchanged.
- R11: Control bit 3 sets the idle level of the master clock. Control bit 2 selects whether data is sampled on the leading edge or the trailing edge. All four combinations exchange bytes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for flag-clearing side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt request |
| sck_in | input | 1 | Serial clock input (slave mode) |
| sck_out | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| sel_in_n | input | 1 | Active-low select input (slave mode) |
| sel_out_n | output | 1 | Active-low select output (master mode) |

## Verification
On every cycle, the assertions check the following. The master clock idles at the programmed level when a byte starts. The clock toggles only when the prescaler reaches its terminal count. A collision is always flagged. The completion flag rises only on a final trailing edge and stays up until a valid clear sequence. A slave that loses its select resets its bit position. The bench scenarios show the things a single-cycle property cannot. These are the exact byte duration for every prescaler and double-speed setting, correct exchanges against a second instance in all four clock modes and all bit-order pairings, recovery after an aborted slave byte, and the order-dependent flag-clearing sequence.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       sel_in_n,
  output logic       sel_out_n
);

  localparam int BITS  = 8;
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [7:0]    ctrl;
  logic          dbl, sel_q, done_f, wcol_f, armed;
  logic [BITS-1:0] shreg, rx_buf;
  logic          rx_bit, out_q, running, s_act, sck_q;
  logic [EW-1:0] edge_cnt;
  logic [5:0]    div_cnt;
  logic [2:0]    sck_s;
  logic [1:0]    ss_s, di_s;
  logic [2:0]    lg2;

  wire [1:0] rate      = ctrl[1:0];
  wire       cpha      = ctrl[2];
  wire       cpol      = ctrl[3];
  wire       is_master = ctrl[4];
  wire       lsb_first = ctrl[5];
  wire       en        = ctrl[6];
  wire       ie        = ctrl[7];

  always_comb begin
    case ({dbl, rate})
      3'b000:  lg2 = 3'd2;
      3'b001:  lg2 = 3'd4;
      3'b010:  lg2 = 3'd6;
      3'b011:  lg2 = 3'd7;
      3'b100:  lg2 = 3'd1;
      3'b101:  lg2 = 3'd3;
      3'b110:  lg2 = 3'd5;
      default: lg2 = 3'd6;
    endcase
  end

  wire [6:0] half    = 7'd1 << (lg2 - 3'd1);
  wire       div_hit = ({1'b0, div_cnt} == half - 7'd1);

  wire s_sel   = en & ~is_master & ~ss_s[1];
  wire s_chg   = s_sel & (sck_s[2] ^ sck_s[1]);
  wire s_lead  = s_chg & (sck_s[2] == cpol);
  wire s_trail = s_chg & (sck_s[2] != cpol);
  wire m_tick  = running & div_hit;
  wire m_lead  = m_tick & ~edge_cnt[0];
  wire m_trail = m_tick &  edge_cnt[0];
  wire lead    = is_master ? m_lead  : s_lead;
  wire trail   = is_master ? m_trail : s_trail;

  wire din      = is_master ? sdi : di_s[1];
  wire samp     = cpha ? din : rx_bit;
  wire [BITS-1:0] shifted = lsb_first ? {samp, shreg[BITS-1:1]} : {shreg[BITS-2:0], samp};
  wire out_bit  = lsb_first ? shreg[0] : shreg[BITS-1];
  wire busy     = is_master ? running : s_act;
  wire byte_done = trail & (edge_cnt == EW'(EDGES - 1));

  wire ctrl_wr  = reg_wr && reg_addr == 2'd0;
  wire data_wr  = reg_wr && reg_addr == 2'd2;
  wire data_rd  = reg_rd && reg_addr == 2'd2;
  wire stat_rd  = reg_rd && reg_addr == 2'd1;
  wire data_acc = data_wr | data_rd;
  wire collide  = data_wr & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      ss_s  <= 2'b11;
      di_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      ss_s  <= {ss_s[0], sel_in_n};
      di_s  <= {di_s[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      dbl   <= 1'b0;
      sel_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: ctrl  <= reg_wdata;
        2'd1: dbl   <= reg_wdata[0];
        2'd3: sel_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      div_cnt <= '0;
      sck_q   <= 1'b0;
    end else begin
      if (!en || !is_master) running <= 1'b0;
      else if (data_wr && !running) running <= 1'b1;
      else if (byte_done) running <= 1'b0;
      if (!running || !en || !is_master) begin
        div_cnt <= '0;
        sck_q   <= cpol;
      end else if (div_hit) begin
        div_cnt <= '0;
        sck_q   <= ~sck_q;
      end else begin
        div_cnt <= div_cnt + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      s_act    <= 1'b0;
    end else begin
      if ((is_master && !running) || (!is_master && !s_sel)) edge_cnt <= '0;
      else if (lead || trail) edge_cnt <= edge_cnt + 1'b1;
      if (!s_sel || byte_done) s_act <= 1'b0;
      else if (s_lead) s_act <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      rx_buf <= '0;
      rx_bit <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (data_wr && !busy) shreg <= reg_wdata;
      else if (trail) shreg <= shifted;
      if (lead) begin
        rx_bit <= din;
        out_q  <= out_bit;
      end
      if (byte_done) rx_buf <= shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0;
      wcol_f <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (stat_rd && (done_f || wcol_f)) armed <= 1'b1;
      else if (data_acc) armed <= 1'b0;
      if (byte_done) done_f <= 1'b1;
      else if (armed && data_acc) done_f <= 1'b0;
      if (collide) wcol_f <= 1'b1;
      else if (armed && data_acc) wcol_f <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl;
      2'd1:    reg_rdata = {done_f, wcol_f, 5'b0, dbl};
      2'd2:    reg_rdata = rx_buf;
      default: reg_rdata = {7'b0, sel_q};
    endcase
  end

  assign irq       = ie & done_f;
  assign sck_out   = sck_q;
  assign sck_oe    = en & is_master;
  assign sdo       = cpha ? out_q : out_bit;
  assign sdo_oe    = en & (is_master | ~ss_s[1]);
  assign sel_out_n = ~sel_q;

  // R8
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && running) |=> wcol_f);

  // R11
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (sck_out == cpol));

  // R5
  sck_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !div_hit && !ctrl_wr) |=> $stable(sck_out));

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(trail));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f && !(armed && data_acc)) |=> done_f);

  // R10
  slave_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && $rose(ss_s[1])) |=> (edge_cnt == '0 && !s_act));

endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [1:0] m_addr = 0, p_addr = 0;
  logic m_wr = 0, m_rd = 0, p_wr = 0, p_rd = 0;
  logic [7:0] m_wdata = 0, p_wdata = 0, m_rdata, p_rdata;
  logic m_irq, p_irq, m_sck, m_sck_oe, p_sck, p_sck_oe;
  logic m_sdo, m_sdo_oe, p_sdo, p_sdo_oe, m_sel_n, p_sel_n;
  wire m_sdi = p_sdo_oe ? p_sdo : m_sdo;

  int checks = 0, errors = 0;
  bit finished = 0;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(m_addr), .reg_wr(m_wr), .reg_rd(m_rd),
    .reg_wdata(m_wdata), .reg_rdata(m_rdata), .irq(m_irq),
    .sck_in(1'b0), .sck_out(m_sck), .sck_oe(m_sck_oe),
    .sdi(m_sdi), .sdo(m_sdo), .sdo_oe(m_sdo_oe),
    .sel_in_n(1'b1), .sel_out_n(m_sel_n));

  spi_port u_peer (
    .clk(clk), .rst_n(rst_n), .reg_addr(p_addr), .reg_wr(p_wr), .reg_rd(p_rd),
    .reg_wdata(p_wdata), .reg_rdata(p_rdata), .irq(p_irq),
    .sck_in(m_sck), .sck_out(p_sck), .sck_oe(p_sck_oe),
    .sdi(m_sdo), .sdo(p_sdo), .sdo_oe(p_sdo_oe),
    .sel_in_n(m_sel_n), .sel_out_n(p_sel_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit peer, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (peer) begin p_addr = a; p_wdata = d; p_wr = 1; end
    else begin m_addr = a; m_wdata = d; m_wr = 1; end
    @(negedge clk);
    p_wr = 0; m_wr = 0;
  endtask

  task automatic rd(input bit peer, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (peer) begin p_addr = a; p_rd = 1; #1 d = p_rdata; end
    else begin m_addr = a; m_rd = 1; #1 d = m_rdata; end
    @(negedge clk);
    p_rd = 0; m_rd = 0;
  endtask

  task automatic peek(input bit peer, input logic [1:0] a, output logic [7:0] d);
    if (peer) begin p_addr = a; #1 d = p_rdata; end
    else begin m_addr = a; #1 d = m_rdata; end
  endtask

  task automatic wait_done(input bit peer, output int cyc);
    logic [7:0] s;
    cyc = 0;
    s = 0;
    while (!s[7] && cyc < 5000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      peek(peer, 2'd1, s);
    end
  endtask

  task automatic clear_flags(input bit peer);
    logic [7:0] d;
    rd(peer, 2'd1, d);
    rd(peer, 2'd2, d);
  endtask

  function automatic logic [7:0] rev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic exchange(input int mode, input bit lm, input bit lp,
                          input logic [7:0] tm, input logic [7:0] tp);
    logic [7:0] d;
    int cyc;
    wr(0, 2'd0, {1'b0, 1'b1, lm, 1'b1, mode[1], mode[0], 2'd1});
    wr(1, 2'd0, {1'b0, 1'b1, lp, 1'b0, mode[1], mode[0], 2'd0});
    wr(1, 2'd2, tp);
    repeat (3) @(negedge clk);
    chk(m_sck == mode[1], "R11 idle clock level", m_sck, mode[1]);
    wr(0, 2'd3, 8'h01);
    chk(m_sel_n == 1'b0, "R3 select low", m_sel_n, 0);
    repeat (4) @(negedge clk);
    wr(0, 2'd2, tm);
    wait_done(0, cyc);
    repeat (8) @(negedge clk);
    peek(1, 2'd1, d);
    chk(d[7], "R2 slave completion", d, 8'h80);
    peek(0, 2'd2, d);
    chk(d == ((lm == lp) ? tp : rev(tp)), "R1 R4 R11 master rx", d, (lm == lp) ? tp : rev(tp));
    peek(1, 2'd2, d);
    chk(d == ((lm == lp) ? tm : rev(tm)), "R1 R4 R11 slave rx", d, (lm == lp) ? tm : rev(tm));
    wr(0, 2'd3, 8'h00);
    chk(m_sel_n == 1'b1, "R3 select high", m_sel_n, 1);
    clear_flags(0);
    clear_flags(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, tx;
    int cyc, lg, expc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(0, 2'd0, d);  chk(d == 0, "R2 reset control", d, 0);
    peek(0, 2'd1, d);  chk(d == 0, "R7 reset status", d, 0);
    chk(m_irq == 0, "R7 reset irq", m_irq, 0);
    chk(m_sel_n == 1, "R3 reset select", m_sel_n, 1);
    chk(m_sck_oe == 0 && m_sdo_oe == 0, "R2 reset drivers", {m_sck_oe, m_sdo_oe}, 0);

    // R5 R6 R7 rate sweep, loopback
    for (int db = 0; db < 2; db++) begin
      for (int r = 0; r < 4; r++) begin
        wr(0, 2'd1, 8'(db));
        wr(0, 2'd0, 8'hD0 | 8'(r));
        chk(m_sck_oe == 1, "R2 master drives clock", m_sck_oe, 1);
        tx = 8'h35 + 8'(r * 17 + db);
        wr(0, 2'd2, tx);
        wait_done(0, cyc);
        lg = db ? ((r == 3) ? 6 : 2 * r + 1) : ((r == 3) ? 7 : 2 * r + 2);
        expc = 16 * (1 << (lg - 1));
        chk(cyc == expc, db ? "R6 double speed byte time" : "R5 byte time", cyc, expc);
        chk(m_irq == 1, "R7 irq on completion", m_irq, 1);
        peek(0, 2'd2, d);
        chk(d == tx, "R1 loopback rx", d, tx);
        clear_flags(0);
        chk(m_irq == 0, "R9 irq cleared", m_irq, 0);
      end
    end
    wr(0, 2'd1, 8'h00);

    // R11 R4 R1 modes and bit orders against the peer
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 4; o++) begin
        exchange(m, o[0], o[1], 8'hA1 ^ 8'(m * 29 + o * 7), 8'h3C + 8'(m * 11 + o));
        chk(p_sck_oe == 0, "R2 slave clock not driven", p_sck_oe, 0);
      end

    // R8 collision
    wr(0, 2'd0, 8'h53);
    wr(0, 2'd2, 8'h96);
    repeat (100) @(negedge clk);
    wr(0, 2'd2, 8'h0F);
    peek(0, 2'd1, d);
    chk(d[6] == 1, "R8 collision flag", d, 8'h40);
    wait_done(0, cyc);
    chk(cyc < 5000, "R8 transfer continued", cyc, 2048);
    peek(0, 2'd2, d);
    chk(d == 8'h96, "R8 write ignored", d, 8'h96);
    chk(m_irq == 0, "R7 irq masked", m_irq, 0);

    // R9 clear ordering
    rd(0, 2'd2, d);
    peek(0, 2'd1, d);
    chk(d[7:6] == 2'b11, "R9 data read alone keeps flags", d[7:6], 3);
    rd(0, 2'd1, d);
    rd(0, 2'd2, d);
    peek(0, 2'd1, d);
    chk(d[7:6] == 2'b00, "R9 sequence clears flags", d[7:6], 0);

    // R10 slave abort
    wr(0, 2'd0, 8'h53);
    wr(1, 2'd0, 8'h40);
    wr(1, 2'd2, 8'h5A);
    wr(0, 2'd3, 8'h01);
    repeat (4) @(negedge clk);
    chk(p_sdo_oe == 1, "R2 selected slave drives", p_sdo_oe, 1);
    peek(1, 2'd2, tx);
    wr(0, 2'd2, 8'hC3);
    repeat (300) @(negedge clk);
    wr(0, 2'd3, 8'h00);
    repeat (5) @(negedge clk);
    chk(p_sdo_oe == 0, "R10 output released", p_sdo_oe, 0);
    wait_done(0, cyc);
    repeat (8) @(negedge clk);
    peek(1, 2'd1, d);
    chk(d[7] == 0, "R10 no completion", d, 0);
    peek(1, 2'd2, d);
    chk(d == tx, "R10 rx unchanged", d, tx);
    clear_flags(0);
    exchange(0, 0, 0, 8'h81, 8'h7E);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule